// File: doc/BRIEF.md
# Segment Translation and Limit Checker

This block turns a logical address, given as a segment number and an offset, into a linear address. It reads a small table of segment descriptors held in flip-flops inside the block. Each descriptor has a 32-bit base, a 32-bit limit and a read-only flag. A separate length register sets how many of the table's leading entries are in use. The table and the length are loaded through a simple write port, one entry per cycle.

A lookup is presented on one cycle with a segment number, an offset and a read/write flag. The result appears on the next cycle as a one-cycle valid pulse. It carries either the translated address or a fault with a cause code. Three checks run in a fixed order, and only the first one that fails is reported: the segment number against the length, the offset against the entry's limit, and a write against the read-only flag. The translated address is the base plus the offset, wrapping modulo 2^32.

Top module: `seg_xlate`

## Requirements
- R1: After reset, out_valid, out_fault, out_cause and out_addr are all zero. Every table entry is all zero and the length is zero, so any lookup faults with cause 2'b01.
- R2: A lookup whose segment number is greater than or equal to the length register faults with cause 2'b01.
- R3: A lookup whose offset is greater than or equal to the entry's limit faults with cause 2'b10. An offset equal to limit-1 is legal.
- R4: A write lookup (req_write=1) to an entry whose read-only flag is set faults with cause 2'b11. A read lookup to that entry is legal, and so is a write lookup to an entry whose flag is clear.
- R5: When several checks fail at once, the reported cause is the first in the order segment bound, limit, write protection.
- R6: A legal lookup returns out_fault=0, out_cause=2'b00 and out_addr = base + offset modulo 2^32.
- R7: out_valid is high in exactly the cycle after a cycle with req_valid high. When out_fault is high, out_addr is zero. When out_valid is low, out_fault, out_cause and out_addr are all zero.
- R8: A table write or length write in the same cycle as a lookup does not affect that lookup. The lookup uses the old contents, and the new contents apply from the next cycle.
- R9: tbl_we loads tbl_base, tbl_limit and tbl_ro into entry tbl_idx. len_we loads len_val into the length register. Lookups in later cycles use the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Write enable for one table entry |
| tbl_idx | input | SEG_W | Entry to write |
| tbl_base | input | 32 | Base value to store |
| tbl_limit | input | 32 | Limit value to store |
| tbl_ro | input | 1 | Read-only flag to store |
| len_we | input | 1 | Write enable for the length register |
| len_val | input | SEG_W+1 | Number of entries in use |
| req_valid | input | 1 | Lookup request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | 32 | Offset within the segment |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_addr | output | 32 | Linear address, zero on a fault |
| out_fault | output | 1 | Lookup faulted |
| out_cause | output | 2 | 00 none, 01 segment bound, 10 limit, 11 write protect |

## Verification
Several properties are checked by assertions on every cycle:
- the one-cycle valid timing and zeroed outputs outside a valid pulse;
- agreement between the fault flag and the cause code, and the zero address on faults;
- the segment-bound fault against the held length;
- that a table write lands in the addressed entry.

The other behaviours need the bench's scenarios against its own model of the table:
- the correct wrapped sum;
- the exact limit boundary at limit and limit-1;
- the priority between causes when several checks fail;
- the old-contents result when a write and a lookup of the same entry share a cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  parameter int unsigned SX_ADDR_W = 32;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_SEG   = 2'b01,
    CAUSE_LIMIT = 2'b10,
    CAUSE_WPROT = 2'b11
  } fault_cause_e;

  typedef struct packed {
    logic [SX_ADDR_W-1:0] base;
    logic [SX_ADDR_W-1:0] limit;
    logic                 ro;
  } seg_desc_t;

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  seg_desc_t        wr_entry,
  input  logic [SEG_W-1:0] rd_idx,
  output seg_desc_t        rd_entry
);

  localparam int unsigned ENTRIES = 1 << SEG_W;

  seg_desc_t entry_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic      load;
    seg_desc_t entry_d;

    always_comb begin
      load    = wr_en && (wr_idx == SEG_W'(g));
      entry_d = load ? wr_entry : entry_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[g] <= '0;
      end else if (load) begin
        entry_q[g] <= entry_d;
      end
    end
  end

  always_comb begin
    rd_entry = entry_q[rd_idx];
  end

  // R9
  entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> entry_q[$past(wr_idx)] == $past(wr_entry));

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W = 4
) (
  input  logic                 [SEG_W-1:0] seg,
  input  logic                 [SEG_W:0]   len,
  input  logic                 [SX_ADDR_W-1:0] off,
  input  logic                             is_write,
  input  seg_desc_t                        entry,
  output fault_cause_e                     cause,
  output logic                 [SX_ADDR_W-1:0] lin_addr
);

  logic seg_bad;
  logic lim_bad;
  logic wp_bad;

  always_comb begin
    seg_bad  = ({1'b0, seg} >= len);
    lim_bad  = (off >= entry.limit);
    wp_bad   = is_write && entry.ro;
    lin_addr = entry.base + off;
    if (seg_bad) begin
      cause = CAUSE_SEG;
    end else if (lim_bad) begin
      cause = CAUSE_LIMIT;
    end else if (wp_bad) begin
      cause = CAUSE_WPROT;
    end else begin
      cause = CAUSE_NONE;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tbl_we,
  input  logic [SEG_W-1:0]     tbl_idx,
  input  logic [SX_ADDR_W-1:0] tbl_base,
  input  logic [SX_ADDR_W-1:0] tbl_limit,
  input  logic                 tbl_ro,
  input  logic                 len_we,
  input  logic [SEG_W:0]       len_val,
  input  logic                 req_valid,
  input  logic [SEG_W-1:0]     req_seg,
  input  logic [SX_ADDR_W-1:0] req_off,
  input  logic                 req_write,
  output logic                 out_valid,
  output logic [SX_ADDR_W-1:0] out_addr,
  output logic                 out_fault,
  output logic [1:0]           out_cause
);

  localparam int unsigned LEN_W = SEG_W + 1;

  seg_desc_t            wr_entry;
  seg_desc_t            rd_entry;
  fault_cause_e         cause;
  logic [SX_ADDR_W-1:0] lin_addr;

  logic [LEN_W-1:0]     len_q, len_d;
  logic                 valid_q, valid_d;
  logic                 fault_q, fault_d;
  logic [1:0]           cause_q, cause_d;
  logic [SX_ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    wr_entry.base  = tbl_base;
    wr_entry.limit = tbl_limit;
    wr_entry.ro    = tbl_ro;
  end

  seg_table #(.SEG_W(SEG_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_idx),
    .wr_entry (wr_entry),
    .rd_idx   (req_seg),
    .rd_entry (rd_entry)
  );

  seg_check #(.SEG_W(SEG_W)) u_check (
    .seg      (req_seg),
    .len      (len_q),
    .off      (req_off),
    .is_write (req_write),
    .entry    (rd_entry),
    .cause    (cause),
    .lin_addr (lin_addr)
  );

  // next state
  always_comb begin
    len_d   = len_we ? len_val : len_q;
    valid_d = req_valid;
    fault_d = req_valid && (cause != CAUSE_NONE);
    cause_d = req_valid ? cause : CAUSE_NONE;
    addr_d  = (req_valid && (cause == CAUSE_NONE)) ? lin_addr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_we) begin
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
      cause_q <= cause_d;
      addr_q  <= addr_d;
    end
  end

  always_comb begin
    out_valid = valid_q;
    out_fault = fault_q;
    out_cause = cause_q;
    out_addr  = addr_q;
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && !out_fault && out_cause == 2'b00 && out_addr == '0);

  // R7
  fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_valid && out_addr == '0 && out_cause != 2'b00);

  // R6
  ok_cause_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fault) |-> out_cause == 2'b00);

  // R2
  seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_seg} >= len_q)) |=> out_fault && out_cause == 2'b01);

endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

  localparam int SEG_W = 4;
  localparam int NENT  = 1 << SEG_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tbl_we = 1'b0;
  logic [SEG_W-1:0] tbl_idx = '0;
  logic [31:0]      tbl_base = '0;
  logic [31:0]      tbl_limit = '0;
  logic             tbl_ro = 1'b0;
  logic             len_we = 1'b0;
  logic [SEG_W:0]   len_val = '0;
  logic             req_valid = 1'b0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [31:0]      req_off = '0;
  logic             req_write = 1'b0;
  logic             out_valid;
  logic [31:0]      out_addr;
  logic             out_fault;
  logic [1:0]       out_cause;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_base [NENT];
  logic [31:0] m_lim  [NENT];
  logic        m_ro   [NENT];
  int          m_len;

  logic        p_valid;
  logic [31:0] p_addr;
  logic [1:0]  p_cause;
  string       p_tag;
  bit          p_live = 0;

  always #2.5 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W)) i_seg_xlate (
    .clk, .rst_n, .tbl_we, .tbl_idx, .tbl_base, .tbl_limit, .tbl_ro,
    .len_we, .len_val, .req_valid, .req_seg, .req_off, .req_write,
    .out_valid, .out_addr, .out_fault, .out_cause
  );

  function automatic logic [1:0] exp_cause(int seg, logic [31:0] off, bit wr);
    if (seg >= m_len)       return 2'b01;
    if (off >= m_lim[seg])  return 2'b10;
    if (wr && m_ro[seg])    return 2'b11;
    return 2'b00;
  endfunction

  task automatic check_out(string tag, bit v, logic [1:0] c, logic [31:0] a);
    bit f;
    f = (c != 2'b00);
    checks++;
    if (out_valid !== v || out_fault !== f || out_cause !== c || out_addr !== a) begin
      errors++;
      $display("FAIL %s: actual v=%0b f=%0b c=%0d a=%h expected v=%0b f=%0b c=%0d a=%h",
               tag, out_valid, out_fault, out_cause, out_addr, v, f, c, a);
    end
  endtask

  // One cycle: check the previous cycle's result, then drive new inputs.
  task automatic step(bit we, int idx, logic [31:0] b, logic [31:0] l, bit ro,
                      bit lwe, int lv, bit rv, int seg, logic [31:0] off, bit wr,
                      string tag);
    logic [1:0] c;
    @(negedge clk);
    if (p_live) check_out(p_tag, p_valid, p_cause, p_addr);
    tbl_we = we; tbl_idx = SEG_W'(idx); tbl_base = b; tbl_limit = l; tbl_ro = ro;
    len_we = lwe; len_val = (SEG_W+1)'(lv);
    req_valid = rv; req_seg = SEG_W'(seg); req_off = off; req_write = wr;
    c = rv ? exp_cause(seg, off, wr) : 2'b00;
    p_valid = rv;
    p_cause = c;
    p_addr  = (rv && c == 2'b00) ? m_base[seg] + off : 32'h0;
    p_tag   = tag;
    if (tag == "") begin
      case (c)
        2'b01:   p_tag = "R2 seg bound";
        2'b10:   p_tag = "R3 limit";
        2'b11:   p_tag = "R4 write protect";
        default: p_tag = rv ? "R6 translate" : "R7 idle";
      endcase
    end
    p_live = 1;
    if (we) begin m_base[idx] = b; m_lim[idx] = l; m_ro[idx] = ro; end
    if (lwe) m_len = lv;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    int unsigned seed;
    for (int i = 0; i < NENT; i++) begin m_base[i] = 0; m_lim[i] = 0; m_ro[i] = 0; end
    m_len = 0;
    seed = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_out("R1 reset outputs", 0, 2'b00, 32'h0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h0, 0, "R1 empty table faults");
    // R9 load entries and length
    step(1, 2, 32'hFFFF_FF00, 32'h200, 1, 0, 0, 0, 0, 0, 0, "R7 idle");
    step(1, 1, 32'h1000_0000, 32'h40, 0, 1, 3, 0, 0, 0, 0, "R7 idle");
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h10, 1, "R9 loaded rw entry write");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 32'h1FF, 0, "R6 wrap and R3 limit-1 legal");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 32'h200, 0, "R3 offset equal limit");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 32'h10, 1, "R4 write to read-only");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 32'h10, 0, "R4 read of read-only");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 32'h300, 1, "R5 limit beats write protect");
    step(0, 0, 0, 0, 0, 0, 0, 1, 3, 32'hFFFF_FFFF, 1, "R5 bound beats limit");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h0, 0, "R3 zero limit");
    // R8 same-cycle write of looked-up entry
    step(1, 1, 32'h2000_0000, 32'h8, 1, 0, 0, 1, 1, 32'h20, 1, "R8 old entry used");
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h4, 1, "R8 new entry next cycle");
    step(0, 0, 0, 0, 0, 1, 1, 1, 2, 32'h4, 0, "R8 old length used");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 32'h4, 0, "R8 new length applies");
    idle("R7 gap");
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int seg;
      int idx;
      logic [31:0] off;
      logic [31:0] lim;
      idx = $urandom_range(NENT-1);
      lim = ($urandom_range(3) == 0) ? $urandom : 32'($urandom_range(64));
      seg = $urandom_range(NENT-1);
      case ($urandom_range(3))
        0: off = $urandom;
        1: off = m_lim[seg];
        2: off = m_lim[seg] - 1;
        default: off = 32'($urandom_range(80));
      endcase
      step($urandom_range(3) == 0, idx, $urandom, lim, $urandom_range(1),
           $urandom_range(15) == 0, $urandom_range(NENT), $urandom_range(4) != 0,
           seg, off, $urandom_range(1), "");
    end
    idle("R7 flush");
    idle("R7 flush");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule